// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is the slave side of a two-channel PCM serial link. It receives a bit clock and a word (or frame) clock from outside, all sampled in its own system clock domain. On the playback side it gathers serial data into a left and a right sample word. When a complete pair has arrived, it presents both words at once with a one-cycle strobe. On the capture side it takes a left/right sample pair from the core and shifts it out serially, MSB first.

A 3-bit format code selects one of seven framings. The framings differ in word length (16 or 18 bits) and in where the word sits relative to the word clock: MSB at the channel start, one bit after it, LSB at the channel end, or a short frame pulse with both words back to back. The same code governs both directions. The block generates no clocks and does no filtering or conversion.

Top module: `audio_serial_port`

## Requirements
- R1: While reset is held and directly after it, `pair_valid`, `sdout`, `play_left` and `play_right` are all zero.
- R2: Format codes: 000 = 18-bit delayed-MSB, 001 = 18-bit MSB-at-start, 010 = 18-bit LSB-at-end, 011 = 16-bit delayed-MSB, 100 = 16-bit MSB-at-start, 101 = 16-bit LSB-at-end, 110 = 16-bit frame-pulse. Words travel MSB first. A 16-bit word occupies bits 17:2 of the 18-bit ports, and its bits 1:0 are zero.
- R3: Code 111 is reserved and behaves exactly like code 000.
- R4: Channel marking by format:
  - MSB-at-start and LSB-at-end: word clock high marks left.
  - Delayed-MSB: word clock low marks left, and the first bit of each channel comes one bit clock after the word clock changes.
  - Frame-pulse: a one-bit-clock high pulse on the word clock, with the left MSB in the next bit slot and the right MSB directly after the left LSB.
- R5: `sdin` is taken on rising bit clock edges. `sdout` changes only after falling bit clock edges.
- R6: In LSB-at-end formats, the last N bits of each channel form the word. On capture, the word is placed so that its LSB falls in the last bit slot of the channel, using the length of the preceding channel.
- R7: `pair_valid` is a one-cycle pulse, once per received pair, and `play_left`/`play_right` change only in that cycle.
  - Frame-pulse format: the pulse follows the right LSB.
  - All other formats: the pulse follows the start of the next left channel.
- R8: In MSB-first formats other than LSB-at-end, a channel that carries fewer than N bits yields a word whose missing LSBs are zero. Bits past the N-th are ignored.
- R9: `cap_left` and `cap_right` are latched together at the start of each left channel. Changes later in the frame do not affect the words sent in that frame.
- R10: In bit slots outside the word, `sdout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt | input | 3 | Format code |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| wclk | input | 1 | Word / frame clock (asynchronous) |
| sdin | input | 1 | Playback serial data |
| cap_left | input | 18 | Capture sample, left |
| cap_right | input | 18 | Capture sample, right |
| sdout | output | 1 | Capture serial data |
| play_left | output | 18 | Received left word |
| play_right | output | 18 | Received right word |
| pair_valid | output | 1 | One-cycle strobe: new pair on play ports |

## Verification
A wrong bit position or channel state shows up on `sdout` within the same bit slot. Every slot of every checked frame is compared, so a slip of one bit clock is caught at once. A receive-side fault stays hidden until the next pair strobe, at most one frame later, when both words are compared in full. A missing or extra strobe shows as a leftover or unexpected entry in the reference queue. A capture latch that tracks the inputs too long is exposed because the bench scrambles both capture inputs early in every left channel.

// File: rtl/asp_pkg.sv
`timescale 1ns/1ps
package asp_pkg;
  localparam int WORD_W  = 18;
  localparam int SHORT_W = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {FR_DELAYED, FR_MSB_START, FR_LSB_END, FR_PULSE} framing_e;
  typedef enum logic {CH_LEFT, CH_RIGHT} chan_e;

  function automatic framing_e fmt_framing(input logic [2:0] code);
    case (code)
      3'b001, 3'b100: return FR_MSB_START;
      3'b010, 3'b101: return FR_LSB_END;
      3'b110:         return FR_PULSE;
      default:        return FR_DELAYED;
    endcase
  endfunction

  function automatic int unsigned fmt_len(input logic [2:0] code);
    case (code)
      3'b011, 3'b100, 3'b101, 3'b110: return SHORT_W;
      default:                         return WORD_W;
    endcase
  endfunction

  // Move an LSB-aligned shift register image to MSB alignment.
  function automatic word_t msb_align(input word_t sr, input int unsigned len);
    return word_t'(sr << (WORD_W - len));
  endfunction

  // Bit sent in slot pos of a channel, word starting at slot off.
  function automatic logic tx_pick(input word_t w, input int unsigned pos,
                                   input int unsigned off, input int unsigned len);
    word_t sh;
    if (pos < off || (pos - off) >= len) return 1'b0;
    sh = w << (pos - off);
    return sh[WORD_W-1];
  endfunction
endpackage

// File: rtl/asp_sync.sv
`timescale 1ns/1ps
module asp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic wclk_in,
  input  logic sdin_in,
  output logic rise,
  output logic fall,
  output logic wclk_s,
  output logic sdin_s
);
  logic [STAGES-1:0] b_q, w_q, d_q;
  logic b_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q <= '0; w_q <= '0; d_q <= '0; b_last <= 1'b0;
    end else begin
      b_q    <= {b_q[STAGES-2:0], bclk_in};
      w_q    <= {w_q[STAGES-2:0], wclk_in};
      d_q    <= {d_q[STAGES-2:0], sdin_in};
      b_last <= b_q[STAGES-1];
    end
  end

  assign rise   = b_q[STAGES-1] & ~b_last;
  assign fall   = ~b_q[STAGES-1] & b_last;
  assign wclk_s = w_q[STAGES-1];
  assign sdin_s = d_q[STAGES-1];
endmodule

// File: rtl/asp_frame_track.sv
`timescale 1ns/1ps
module asp_frame_track import asp_pkg::*; #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             wclk,
  input  framing_e         framing,
  output logic             start_left,
  output logic             start_right,
  output chan_e            ch,
  output logic [POS_W-1:0] pos
);
  logic w1, w2;
  chan_e ch_q;
  logic [POS_W-1:0] pos_q;

  always_comb begin
    case (framing)
      FR_DELAYED: begin
        start_left  = ~w1 & w2;
        start_right = w1 & ~w2;
      end
      FR_PULSE: begin
        start_left  = w1 & ~w2;
        start_right = ~start_left && ch_q == CH_LEFT && pos_q == POS_W'(SHORT_W-1);
      end
      default: begin
        start_left  = wclk & ~w1;
        start_right = ~wclk & w1;
      end
    endcase
    ch  = ch_q;
    pos = (pos_q == '1) ? pos_q : pos_q + 1'b1;
    if (start_left || start_right) begin
      ch  = start_left ? CH_LEFT : CH_RIGHT;
      pos = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w1 <= 1'b0; w2 <= 1'b0; ch_q <= CH_RIGHT; pos_q <= '0;
    end else if (step) begin
      w1 <= wclk; w2 <= w1; ch_q <= ch; pos_q <= pos;
    end
  end
endmodule

// File: rtl/asp_rx.sv
`timescale 1ns/1ps
module asp_rx import asp_pkg::*; #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             sdin,
  input  framing_e         framing,
  input  logic [4:0]       word_len,
  input  logic             start_left,
  input  logic             start_right,
  input  chan_e            ch,
  input  logic [POS_W-1:0] pos,
  output word_t            play_left,
  output word_t            play_right,
  output logic             pair_valid
);
  word_t cur_q, hold_q, base, nxt, fin;
  logic  have_left_q, pair_done;

  always_comb begin
    base = (start_left || start_right) ? '0 : cur_q;
    if (framing == FR_LSB_END)
      nxt = {base[WORD_W-2:0], sdin};
    else if (32'(pos) < 32'(word_len))
      nxt = base | ({sdin, {(WORD_W-1){1'b0}}} >> pos);
    else
      nxt = base;
    fin = (framing == FR_LSB_END) ? msb_align(cur_q, 32'(word_len)) : cur_q;
  end

  always_comb begin
    if (framing == FR_PULSE)
      pair_done = step && have_left_q && ch == CH_RIGHT && pos == POS_W'(SHORT_W-1);
    else
      pair_done = step && have_left_q && start_left;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0; hold_q <= '0; have_left_q <= 1'b0;
      play_left <= '0; play_right <= '0; pair_valid <= 1'b0;
    end else begin
      pair_valid <= pair_done;
      if (step) cur_q <= nxt;
      if (pair_done) begin
        have_left_q <= 1'b0;
        play_left   <= hold_q;
        play_right  <= (framing == FR_PULSE) ? nxt : fin;
      end
      if (step && start_right) begin
        hold_q      <= fin;
        have_left_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/asp_tx.sv
`timescale 1ns/1ps
module asp_tx import asp_pkg::*; #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  framing_e         framing,
  input  logic [4:0]       word_len,
  input  logic             start_left,
  input  logic             start_right,
  input  chan_e            ch,
  input  logic [POS_W-1:0] pos,
  input  word_t            cap_left,
  input  word_t            cap_right,
  output logic             sdout
);
  word_t txl_q, txr_q, cur;
  logic [POS_W-1:0] last_pos_q;
  int unsigned span_q, span_now, off;
  logic bit_now;

  always_comb begin
    span_now = (start_left || start_right) ? 32'(last_pos_q) + 1 : span_q;
    off = (framing == FR_LSB_END && span_now >= 32'(word_len)) ? span_now - 32'(word_len) : 0;
    cur = (ch == CH_LEFT) ? (start_left ? cap_left : txl_q) : txr_q;
    bit_now = tx_pick(cur, 32'(pos), off, 32'(word_len));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txl_q <= '0; txr_q <= '0; last_pos_q <= '0; span_q <= 0; sdout <= 1'b0;
    end else if (step) begin
      sdout      <= bit_now;
      last_pos_q <= pos;
      span_q     <= span_now;
      if (start_left) begin
        txl_q <= cap_left;
        txr_q <= cap_right;
      end
    end
  end
endmodule

// File: rtl/audio_serial_port.sv
`timescale 1ns/1ps
module audio_serial_port import asp_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        fmt,
  input  logic              bclk,
  input  logic              wclk,
  input  logic              sdin,
  input  logic [WORD_W-1:0] cap_left,
  input  logic [WORD_W-1:0] cap_right,
  output logic              sdout,
  output logic [WORD_W-1:0] play_left,
  output logic [WORD_W-1:0] play_right,
  output logic              pair_valid
);
  logic [2:0] fmt_eff;
  framing_e   framing;
  logic [4:0] word_len;
  logic rise_evt, fall_evt, wclk_s, sdin_s;
  logic rx_sl, rx_sr, tx_sl, tx_sr;
  chan_e rx_ch, tx_ch;
  logic [POS_W-1:0] rx_pos, tx_pos;

  assign fmt_eff  = (fmt == 3'b111) ? 3'b000 : fmt;
  assign framing  = fmt_framing(fmt_eff);
  assign word_len = 5'(fmt_len(fmt_eff));

  asp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_in(bclk), .wclk_in(wclk), .sdin_in(sdin),
    .rise(rise_evt), .fall(fall_evt), .wclk_s(wclk_s), .sdin_s(sdin_s));

  asp_frame_track #(.POS_W(POS_W)) u_rx_trk (
    .clk(clk), .rst(rst), .step(rise_evt), .wclk(wclk_s), .framing(framing),
    .start_left(rx_sl), .start_right(rx_sr), .ch(rx_ch), .pos(rx_pos));

  asp_frame_track #(.POS_W(POS_W)) u_tx_trk (
    .clk(clk), .rst(rst), .step(fall_evt), .wclk(wclk_s), .framing(framing),
    .start_left(tx_sl), .start_right(tx_sr), .ch(tx_ch), .pos(tx_pos));

  asp_rx #(.POS_W(POS_W)) u_rx (
    .clk(clk), .rst(rst), .step(rise_evt), .sdin(sdin_s), .framing(framing),
    .word_len(word_len), .start_left(rx_sl), .start_right(rx_sr), .ch(rx_ch),
    .pos(rx_pos), .play_left(play_left), .play_right(play_right),
    .pair_valid(pair_valid));

  asp_tx #(.POS_W(POS_W)) u_tx (
    .clk(clk), .rst(rst), .step(fall_evt), .framing(framing), .word_len(word_len),
    .start_left(tx_sl), .start_right(tx_sr), .ch(tx_ch), .pos(tx_pos),
    .cap_left(cap_left), .cap_right(cap_right), .sdout(sdout));
endmodule

// File: rtl/audio_serial_port_chk.sv
`timescale 1ns/1ps
module audio_serial_port_chk import asp_pkg::*; (
  input logic  clk,
  input logic  rst,
  input logic  rise_evt,
  input logic  fall_evt,
  input logic  sdout,
  input logic  pair_valid,
  input word_t play_left,
  input word_t play_right
);
  assert_edges_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(rise_evt && fall_evt));

  assert_tx_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdout) |-> $past(fall_evt));

  assert_rx_after_rise_R5: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> $past(rise_evt));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  assert_words_held_R7: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> ($stable(play_left) && $stable(play_right)));
endmodule

bind audio_serial_port audio_serial_port_chk u_chk (
  .clk(clk), .rst(rst), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .sdout(sdout), .pair_valid(pair_valid), .play_left(play_left),
  .play_right(play_right));

// File: tb/audio_serial_port_test.sv
`timescale 1ns/1ps
module audio_serial_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] fmt = 3'b000;
  logic bclk = 1'b1, wclk = 1'b0, sdin = 1'b0;
  logic [17:0] cap_left = '0, cap_right = '0;
  logic sdout, pair_valid;
  logic [17:0] play_left, play_right;

  int checks = 0, failures = 0;
  bit done = 0, ignore = 1;
  string run_tag = "";
  logic [17:0] exp_l[$], exp_r[$];

  always #2 clk = ~clk;

  audio_serial_port uut (
    .clk(clk), .rst(rst), .fmt(fmt), .bclk(bclk), .wclk(wclk), .sdin(sdin),
    .cap_left(cap_left), .cap_right(cap_right), .sdout(sdout),
    .play_left(play_left), .play_right(play_right), .pair_valid(pair_valid));

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Strobe monitor: compare each received pair against the reference queue.
  always @(negedge clk) begin
    if (!rst && pair_valid && !ignore) begin
      if (exp_l.size() == 0) check({"R7 unexpected pair ", run_tag}, 18'h1, 18'h0);
      else begin
        check({"R7 R2 play_left ", run_tag}, play_left, exp_l.pop_front());
        check({"R7 R2 play_right ", run_tag}, play_right, exp_r.pop_front());
      end
    end
  end

  // Bench view of the formats: kind 0 delayed, 1 msb-at-start, 2 lsb-at-end, 3 pulse.
  function automatic void decode(input logic [2:0] code, output int kind, output int n);
    n = 18;
    kind = 0;
    if (code == 3'b001 || code == 3'b100) kind = 1;
    if (code == 3'b010 || code == 3'b101) kind = 2;
    if (code == 3'b110) kind = 3;
    if (code >= 3'b011 && code <= 3'b110) n = 16;
  endfunction

  // For slot s of a frame: word clock level, channel (0 left, 1 right, -1 none), bit index.
  function automatic void slot_map(input int kind, input int n, input int h, input int s,
                                   output logic w, output int chn, output int idx);
    chn = -1; idx = -1;
    case (kind)
      0: begin
        w = (s >= h);
        if (s >= 1 && s <= h) begin chn = 0; idx = s - 1; end
        else if (s > h) begin chn = 1; idx = s - h - 1; end
      end
      1: begin w = (s < h); chn = (s < h) ? 0 : 1; idx = s % h; end
      2: begin w = (s < h); chn = (s < h) ? 0 : 1; idx = (s % h) - (h - n); end
      default: begin
        w = (s == 0);
        if (s >= 1 && s <= 16) begin chn = 0; idx = s - 1; end
        else if (s >= 17 && s <= 32) begin chn = 1; idx = s - 17; end
      end
    endcase
    if (idx < 0 || idx >= n) chn = -1;
  endfunction

  task automatic slot(input logic w, input logic d, input bit chk, input logic e, input string tag);
    @(negedge clk); bclk = 1'b0; wclk = w; sdin = d;
    repeat (7) @(negedge clk);
    if (chk) check(tag, {17'b0, sdout}, {17'b0, e});
    @(negedge clk); bclk = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; bclk = 1'b1; wclk = 1'b0; sdin = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input logic [2:0] code, input int h, input int nfr, input string tag);
    int kind, n, avail;
    logic [17:0] mask;
    decode((code == 3'b111) ? 3'b000 : code, kind, n);
    fmt = code; run_tag = tag;
    do_reset();
    ignore = 1;
    avail = (kind == 3) ? 16 : (kind == 2) ? n : ((h < n) ? h : n);
    mask = ~(18'h3FFFF >> avail);
    for (int f = 0; f < nfr + 2; f++) begin
      logic [17:0] rl = 18'($urandom), rr = 18'($urandom);
      logic [17:0] tl = 18'($urandom), tr = 18'($urandom);
      bit live = (f >= 1 && f <= nfr);
      if (live) begin exp_l.push_back(rl & mask); exp_r.push_back(rr & mask); end
      cap_left = tl; cap_right = tr;
      for (int s = 0; s < 2 * h; s++) begin
        logic w, d, e;
        int chn, idx;
        if (s == 2 && f == 1) ignore = 0;
        if (s == 2 && f == nfr + 1) ignore = 1;
        if (s == 5) begin cap_left = ~tl; cap_right = tr ^ 18'h2AAAA; end
        slot_map(kind, n, h, s, w, chn, idx);
        d = 1'b0; e = 1'b0;
        if (chn == 0) begin d = rl[17 - idx]; e = tl[17 - idx]; end
        if (chn == 1) begin d = rr[17 - idx]; e = tr[17 - idx]; end
        slot(w, d, live, e, $sformatf("R5 R9 R10 sdout %s f=%0d s=%0d", tag, f, s));
      end
    end
    check({"R7 pairs outstanding ", tag}, 18'(exp_l.size()), 18'h0);
    exp_l.delete(); exp_r.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pair_valid in reset", {17'b0, pair_valid}, 18'h0);
    check("R1 play_left in reset", play_left, 18'h0);
    check("R1 play_right in reset", play_right, 18'h0);
    check("R1 sdout in reset", {17'b0, sdout}, 18'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pair_valid after reset", {17'b0, pair_valid}, 18'h0);
    check("R1 play_left after reset", play_left, 18'h0);

    run(3'b000, 20, 4, "R2 R4 delayed-18");
    run(3'b001, 20, 4, "R2 R4 start-18");
    run(3'b010, 24, 4, "R2 R6 end-18");
    run(3'b011, 20, 4, "R2 R4 delayed-16");
    run(3'b100, 20, 4, "R2 R4 start-16");
    run(3'b101, 20, 4, "R2 R6 end-16");
    run(3'b110, 20, 4, "R2 R4 pulse-16");
    run(3'b111, 20, 4, "R3 reserved");
    run(3'b001, 12, 4, "R8 short-18");
    run(3'b100, 12, 4, "R8 short-16");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule